// File: doc/BRIEF.md
# Dispatch Admission and Buffer Tracker

This block sits in front of an out-of-order scheduler and rules, every cycle, whether the instruction offered by the dispatch logic may enter. The instruction is described by a may-load flag, a may-store flag and a bitmask naming the scheduler resources it occupies. Two plain status pins report whether the load queue and the store queue are full. The block keeps an occupancy count for each resource, combines it with the status pins, and answers with a ready bit and a 3-bit stall code.

The dispatch side is a valid/ready stream. `disp_ready` and `stall_code` are combinational and depend only on the offered descriptor, the status pins and the registered occupancy. They do not depend on `disp_valid`, so the producer may look at `disp_ready` before it commits. A transfer happens only in a cycle where both `disp_valid` and `disp_ready` are high. A transfer reserves one entry in every resource named in the mask.

When an instruction issues, the issue pins hand back its mask. Each buffered resource named there gets one entry back. A resource configured with depth zero has no entries. It is instead held exclusively from the cycle of dispatch. It is released once the issue has happened and a given number of further cycles have elapsed.

Top module: `dispatch_admit`

## Requirements
- R1: When the offered instruction may load and `lq_full` is high, `stall_code` is 1 and `disp_ready` is low, whatever else holds.
- R2: Otherwise, when it may store and `sq_full` is high, `stall_code` is 2 and `disp_ready` is low. A full flag whose access kind the instruction lacks has no effect.
- R3: Otherwise, when any buffered resource named in `disp_res_mask` (bit i names resource i) holds as many entries as its depth, `stall_code` is 3 and `disp_ready` is low.
- R4: Otherwise, when any depth-zero resource named in the mask is held, `stall_code` is 4 and `disp_ready` is low.
- R5: When none of these holds, `disp_ready` is 1 and `stall_code` is 0. A transfer adds one entry to every buffered resource in the mask, visible from the next cycle.
- R6: An issue (`iss_valid` high) removes one entry from every buffered resource in `iss_mask`, visible from the next cycle.
- R7: A depth-zero resource becomes held in the cycle after a transfer that names it. It stays held through the issue cycle and the `iss_hold` cycles that follow. With a hold of 0 it is free in the cycle after the issue.
- R8: A transfer and an issue naming the same buffered resource in one cycle leave its count unchanged.
- R9: After reset every resource is empty and free.
- R10: With `disp_valid` low, or while stalled, nothing is reserved. The stall code is always one of 0 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch offers an instruction |
| disp_ready | output | 1 | Instruction may enter (no stall) |
| disp_may_load | input | 1 | Instruction may read memory |
| disp_may_store | input | 1 | Instruction may write memory |
| disp_res_mask | input | NUM_RES | Resources the instruction occupies |
| lq_full | input | 1 | Load queue has no free slot |
| sq_full | input | 1 | Store queue has no free slot |
| stall_code | output | 3 | 0 none, 1 load queue, 2 store queue, 3 resource full, 4 resource held |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_mask | input | NUM_RES | Resources of the issuing instruction |
| iss_hold | input | HOLD_W | Extra cycles a depth-zero resource stays held after issue |

## Verification
The bench first offers instructions with several full flags raised at once. This separates the four stall causes by priority, including a full flag that does not match the instruction's access kind. It then fills resources of different depths one transfer at a time, to catch off-by-one depth limits. Stalled offers with `disp_valid` high are followed by fills that would fail early if those offers had reserved. Releases are checked alone and in the same cycle as a reserve, which tells correct cancellation from either side winning. Depth-zero resources are checked with hold counts 2 and 0, which exposes a release that comes one cycle early or one cycle late.

// File: rtl/dispatch_admit_pkg.sv
package dispatch_admit_pkg;

  typedef enum logic [2:0] {
    STALL_NONE  = 3'd0,
    STALL_LDQ   = 3'd1,
    STALL_STQ   = 3'd2,
    STALL_ROOM  = 3'd3,
    STALL_HELD  = 3'd4
  } stall_e;

endpackage

// File: rtl/adm_res_slot.sv
module adm_res_slot #(
  parameter int DEPTH_W = 4,
  parameter int HOLD_W  = 4,
  parameter logic [DEPTH_W-1:0] DEPTH = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic               give,
  input  logic [HOLD_W-1:0]  give_hold,
  output logic               no_room,
  output logic               held,
  output logic [DEPTH_W-1:0] occ
);

  generate
    if (DEPTH == '0) begin : g_unbuf
      logic              held_q;
      logic [HOLD_W-1:0] left_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          held_q <= 1'b0;
          left_q <= '0;
        end else begin
          if (take) held_q <= 1'b1;
          if (give) begin
            left_q <= give_hold;
            if (give_hold == '0) held_q <= 1'b0;
          end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
            if (left_q == HOLD_W'(1)) held_q <= 1'b0;
          end
        end
      end

      assign no_room = 1'b0;
      assign held    = held_q;
      assign occ     = {{(DEPTH_W-1){1'b0}}, held_q};
    end else begin : g_buf
      logic [DEPTH_W-1:0] cnt_q;
      logic               unused_hold;

      assign unused_hold = ^give_hold;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else begin
          unique case ({take, give})
            2'b10: if (cnt_q != DEPTH) cnt_q <= cnt_q + 1'b1;
            2'b01: if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
          endcase
        end
      end

      assign no_room = (cnt_q == DEPTH);
      assign held    = 1'b0;
      assign occ     = cnt_q;
    end
  endgenerate

endmodule

// File: rtl/adm_stall_arb.sv
module adm_stall_arb
  import dispatch_admit_pkg::*;
(
  input  logic   may_load,
  input  logic   lq_full,
  input  logic   may_store,
  input  logic   sq_full,
  input  logic   any_no_room,
  input  logic   any_held,
  output stall_e code
);

  always_comb begin
    if (may_load && lq_full)       code = STALL_LDQ;
    else if (may_store && sq_full) code = STALL_STQ;
    else if (any_no_room)          code = STALL_ROOM;
    else if (any_held)             code = STALL_HELD;
    else                           code = STALL_NONE;
  end

endmodule

// File: rtl/dispatch_admit.sv
module dispatch_admit
  import dispatch_admit_pkg::*;
#(
  parameter int NUM_RES = 4,
  parameter int DEPTH_W = 4,
  parameter int HOLD_W  = 4,
  parameter logic [NUM_RES*DEPTH_W-1:0] RES_DEPTHS = {4'd1, 4'd0, 4'd3, 4'd2}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               disp_valid,
  output logic               disp_ready,
  input  logic               disp_may_load,
  input  logic               disp_may_store,
  input  logic [NUM_RES-1:0] disp_res_mask,
  input  logic               lq_full,
  input  logic               sq_full,
  output logic [2:0]         stall_code,
  input  logic               iss_valid,
  input  logic [NUM_RES-1:0] iss_mask,
  input  logic [HOLD_W-1:0]  iss_hold
);

  localparam int OCC_BITS = NUM_RES * DEPTH_W;

  logic [NUM_RES-1:0]  room_gone;
  logic [NUM_RES-1:0]  res_held;
  logic [OCC_BITS-1:0] occ_flat;
  logic                accept;
  stall_e              code;

  assign accept = disp_valid && disp_ready;

  for (genvar i = 0; i < NUM_RES; i++) begin : g_slot
    adm_res_slot #(
      .DEPTH_W (DEPTH_W),
      .HOLD_W  (HOLD_W),
      .DEPTH   (RES_DEPTHS[i*DEPTH_W +: DEPTH_W])
    ) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (accept && disp_res_mask[i]),
      .give      (iss_valid && iss_mask[i]),
      .give_hold (iss_hold),
      .no_room   (room_gone[i]),
      .held      (res_held[i]),
      .occ       (occ_flat[i*DEPTH_W +: DEPTH_W])
    );
  end

  adm_stall_arb u_arb (
    .may_load    (disp_may_load),
    .lq_full     (lq_full),
    .may_store   (disp_may_store),
    .sq_full     (sq_full),
    .any_no_room (|(disp_res_mask & room_gone)),
    .any_held    (|(disp_res_mask & res_held)),
    .code        (code)
  );

  assign stall_code = code;
  assign disp_ready = (code == STALL_NONE);

endmodule

// File: rtl/dispatch_admit_chk.sv
module dispatch_admit_chk #(
  parameter int NUM_RES = 4,
  parameter int DEPTH_W = 4,
  parameter logic [NUM_RES*DEPTH_W-1:0] RES_DEPTHS = '0
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       disp_valid,
  input logic                       disp_ready,
  input logic                       disp_may_load,
  input logic                       disp_may_store,
  input logic [NUM_RES-1:0]         disp_res_mask,
  input logic                       lq_full,
  input logic                       sq_full,
  input logic [2:0]                 stall_code,
  input logic                       iss_valid,
  input logic [NUM_RES-1:0]         iss_mask,
  input logic [NUM_RES*DEPTH_W-1:0] occ_flat
);

  logic acc;
  assign acc = disp_valid && disp_ready;

  AST_LOAD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_may_load && lq_full) |-> (stall_code == 3'd1 && !disp_ready)); // R1

  AST_STORE_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    (!(disp_may_load && lq_full) && disp_may_store && sq_full) |-> (stall_code == 3'd2)); // R2

  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    stall_code <= 3'd4); // R10

  for (genvar i = 0; i < NUM_RES; i++) begin : g_res
    localparam logic [DEPTH_W-1:0] DEP = RES_DEPTHS[i*DEPTH_W +: DEPTH_W];
    if (DEP != '0) begin : g_b
      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ_flat[i*DEPTH_W +: DEPTH_W] <= DEP); // R3
      AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_mask[i] && !(acc && disp_res_mask[i]))
          |-> (occ_flat[i*DEPTH_W +: DEPTH_W] != '0)); // R6
      AST_RESERVE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && disp_res_mask[i] && !(iss_valid && iss_mask[i]))
          |=> (occ_flat[i*DEPTH_W +: DEPTH_W] == $past(occ_flat[i*DEPTH_W +: DEPTH_W]) + 1'b1)); // R5
      AST_RELEASE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_mask[i] && !(acc && disp_res_mask[i]))
          |=> (occ_flat[i*DEPTH_W +: DEPTH_W] == $past(occ_flat[i*DEPTH_W +: DEPTH_W]) - 1'b1)); // R6
      AST_SAME_CYCLE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && disp_res_mask[i] && iss_valid && iss_mask[i])
          |=> $stable(occ_flat[i*DEPTH_W +: DEPTH_W])); // R8
      AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc && !iss_valid) |=> $stable(occ_flat[i*DEPTH_W +: DEPTH_W])); // R10
    end else begin : g_z
      AST_GROUP_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && disp_res_mask[i]) |=> (occ_flat[i*DEPTH_W +: DEPTH_W] != '0)); // R7
      AST_ISSUE_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_mask[i]) |-> (occ_flat[i*DEPTH_W +: DEPTH_W] != '0)); // R7
      AST_HELD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_res_mask[i] && occ_flat[i*DEPTH_W +: DEPTH_W] != '0) |-> !disp_ready); // R4
    end
  end

endmodule

bind dispatch_admit dispatch_admit_chk #(
  .NUM_RES    (NUM_RES),
  .DEPTH_W    (DEPTH_W),
  .RES_DEPTHS (RES_DEPTHS)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .disp_valid     (disp_valid),
  .disp_ready     (disp_ready),
  .disp_may_load  (disp_may_load),
  .disp_may_store (disp_may_store),
  .disp_res_mask  (disp_res_mask),
  .lq_full        (lq_full),
  .sq_full        (sq_full),
  .stall_code     (stall_code),
  .iss_valid      (iss_valid),
  .iss_mask       (iss_mask),
  .occ_flat       (occ_flat)
);

// File: tb/tb_dispatch_admit.sv
`timescale 1ns/100ps
module tb_dispatch_admit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       disp_valid = 1'b0;
  logic       disp_ready;
  logic       disp_may_load = 1'b0;
  logic       disp_may_store = 1'b0;
  logic [3:0] disp_res_mask = '0;
  logic       lq_full = 1'b0;
  logic       sq_full = 1'b0;
  logic [2:0] stall_code;
  logic       iss_valid = 1'b0;
  logic [3:0] iss_mask = '0;
  logic [3:0] iss_hold = '0;

  int checks = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  // resource depths: r0=2, r1=3, r2=0 (held exclusively), r3=1
  dispatch_admit #(
    .NUM_RES(4), .DEPTH_W(4), .HOLD_W(4),
    .RES_DEPTHS({4'd1, 4'd0, 4'd3, 4'd2})
  ) dut (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_may_load(disp_may_load), .disp_may_store(disp_may_store),
    .disp_res_mask(disp_res_mask), .lq_full(lq_full), .sq_full(sq_full),
    .stall_code(stall_code),
    .iss_valid(iss_valid), .iss_mask(iss_mask), .iss_hold(iss_hold)
  );

  task automatic step(input logic v, input logic ld, input logic st,
                      input logic lqf, input logic sqf, input logic [3:0] m,
                      input logic iv, input logic [3:0] im, input logic [3:0] ih,
                      input logic er, input logic [2:0] ec, input string tag);
    @(negedge clk);
    disp_valid = v; disp_may_load = ld; disp_may_store = st;
    lq_full = lqf; sq_full = sqf; disp_res_mask = m;
    iss_valid = iv; iss_mask = im; iss_hold = ih;
    exp_q.push_back({er, ec});
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    disp_valid = 0; disp_may_load = 0; disp_may_store = 0;
    lq_full = 0; sq_full = 0; disp_res_mask = '0;
    iss_valid = 0; iss_mask = '0; iss_hold = '0;
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  // monitor: compares combinational outputs 1 ns after each driving edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({disp_ready, stall_code} !== e) begin
          bad++;
          $display("FAIL %s: actual ready=%0b code=%0d expected ready=%0b code=%0d",
                   t, disp_ready, stall_code, e[3], e[2:0]);
        end
      end
    end
  end

  initial begin
    #20000;
    if (!finished) begin
      checks++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    //    v  ld st lq sq mask     iv im       ih    rdy code
    step(0, 0, 0, 0, 0, 4'b1111, 0, 4'b0000, 4'd0, 1, 3'd0, "R9 all free after reset");
    step(0, 1, 1, 1, 1, 4'b0000, 0, 4'b0000, 4'd0, 0, 3'd1, "R1 load queue first");
    step(0, 0, 1, 1, 1, 4'b0000, 0, 4'b0000, 4'd0, 0, 3'd2, "R2 store queue second");
    step(0, 0, 0, 1, 1, 4'b0000, 0, 4'b0000, 4'd0, 1, 3'd0, "R2 unmatched full flags ignored");
    step(1, 0, 0, 0, 0, 4'b0001, 0, 4'b0000, 4'd0, 1, 3'd0, "R5 accept r0 first");
    step(1, 0, 0, 0, 0, 4'b0001, 0, 4'b0000, 4'd0, 1, 3'd0, "R5 accept r0 second");
    step(0, 0, 0, 0, 0, 4'b0001, 0, 4'b0000, 4'd0, 0, 3'd3, "R3 r0 at depth");
    step(0, 1, 0, 1, 0, 4'b0001, 0, 4'b0000, 4'd0, 0, 3'd1, "R1 load queue over full resource");
    step(1, 0, 0, 0, 0, 4'b0011, 0, 4'b0000, 4'd0, 0, 3'd3, "R10 stalled offer");
    step(1, 0, 0, 0, 0, 4'b0010, 0, 4'b0000, 4'd0, 1, 3'd0, "R10 r1 untouched 1");
    step(1, 0, 0, 0, 0, 4'b0010, 0, 4'b0000, 4'd0, 1, 3'd0, "R10 r1 untouched 2");
    step(1, 0, 0, 0, 0, 4'b0010, 0, 4'b0000, 4'd0, 1, 3'd0, "R10 r1 untouched 3");
    step(0, 0, 0, 0, 0, 4'b0010, 0, 4'b0000, 4'd0, 0, 3'd3, "R3 r1 at depth");
    step(0, 0, 0, 0, 0, 4'b0001, 1, 4'b0001, 4'd0, 0, 3'd3, "R6 release seen next cycle");
    step(1, 0, 0, 0, 0, 4'b0001, 0, 4'b0000, 4'd0, 1, 3'd0, "R6 freed entry reusable");
    step(0, 0, 0, 0, 0, 4'b0001, 1, 4'b0001, 4'd0, 0, 3'd3, "R6 second release");
    step(1, 0, 0, 0, 0, 4'b0001, 1, 4'b0001, 4'd0, 1, 3'd0, "R8 reserve with release");
    step(1, 0, 0, 0, 0, 4'b0001, 0, 4'b0000, 4'd0, 1, 3'd0, "R8 count kept at one");
    step(0, 0, 0, 0, 0, 4'b0001, 0, 4'b0000, 4'd0, 0, 3'd3, "R8 count now at depth");
    step(1, 0, 0, 0, 0, 4'b0100, 0, 4'b0000, 4'd0, 1, 3'd0, "R7 take unbuffered r2");
    step(0, 0, 0, 0, 0, 4'b0100, 0, 4'b0000, 4'd0, 0, 3'd4, "R4 r2 held");
    step(0, 0, 0, 0, 0, 4'b0101, 0, 4'b0000, 4'd0, 0, 3'd3, "R3 full ranks over held");
    step(0, 0, 0, 0, 0, 4'b0100, 1, 4'b0100, 4'd2, 0, 3'd4, "R7 held in issue cycle");
    step(0, 0, 0, 0, 0, 4'b0100, 0, 4'b0000, 4'd0, 0, 3'd4, "R7 hold cycle 1");
    step(0, 0, 0, 0, 0, 4'b0100, 0, 4'b0000, 4'd0, 0, 3'd4, "R7 hold cycle 2");
    step(0, 0, 0, 0, 0, 4'b0100, 0, 4'b0000, 4'd0, 1, 3'd0, "R7 free after hold");
    step(1, 0, 0, 0, 0, 4'b0100, 0, 4'b0000, 4'd0, 1, 3'd0, "R7 retake r2");
    step(0, 0, 0, 0, 0, 4'b0100, 1, 4'b0100, 4'd0, 0, 3'd4, "R7 zero hold issue");
    step(0, 0, 0, 0, 0, 4'b0100, 0, 4'b0000, 4'd0, 1, 3'd0, "R7 free right after issue");
    step(1, 0, 0, 0, 0, 4'b1000, 0, 4'b0000, 4'd0, 1, 3'd0, "R5 accept r3");
    step(0, 0, 0, 0, 0, 4'b1000, 0, 4'b0000, 4'd0, 0, 3'd3, "R3 depth one full");
    idle();
    repeat (3) @(negedge clk);
    finished = 1'b1;
    report();
  end

endmodule